// File: doc/BRIEF.md
# Cross-Trigger Channel Gate

This block sits on the channel side of a debug trigger interface, between the interface's own channel events and a channel matrix that other trigger interfaces share. It holds a gate-enable register with one bit for each implemented channel. Software reaches the register through a simple word-wide read/write port at byte offset 0x140. When a gate bit is 1, that channel's events leave the interface toward the matrix. When it is 0, nothing on that channel goes out. Any event that is being held high on that channel is also cut off.

A build-time direction code sets what the gate bits control. When the code is 2'b01, each gate bit also filters events that come back from the matrix into the interface. With any other code, inbound events pass through without change. A lock input makes the register read-only. The gating is combinational. A new register value therefore acts on the channel outputs right after the clock edge that stores it.

Top module: `xtrig_gate_top`

## Requirements
- R1: After reset the gate register holds zero. Reading it at offset 0x140 returns zero, and no outbound channel is driven whatever the interface presents.
- R2: A write (regSel=1, regWr=1) to offset 0x140 while lockIn=0 stores regWdata[N-1:0] at the clock edge. A later read (regSel=1, regWr=0) of that offset returns the stored bits in regRdata[N-1:0].
- R3: Register bits N to 31 always read as zero, and writing ones to them changes nothing.
- R4: Each outbound channel bit matrixChanOut[x] equals trigChanIn[x] AND gate bit x, with no register stage between them.
- R5: Clearing a gate bit while its channel is held high drives that matrixChanOut bit low from the clock edge that completes the write. The bit stays high before that edge.
- R6: With DIR_MODE = 2'b01, trigChanOut[x] equals matrixChanIn[x] AND gate bit x. With any other DIR_MODE, trigChanOut equals matrixChanIn.
- R7: While lockIn=1, writes leave the register unchanged, and reads still return its value.
- R8: Accesses to any offset other than 0x140 do not change the register, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lockIn | input | 1 | Software lock; 1 makes the register read-only |
| regSel | input | 1 | Register access valid this cycle |
| regWr | input | 1 | 1 for a write, 0 for a read |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data; zero when no read of the gate register is taking place |
| trigChanIn | input | NUM_CHAN | Channel events from the interface, going toward the matrix |
| matrixChanOut | output | NUM_CHAN | Gated channel events driven to the matrix |
| matrixChanIn | input | NUM_CHAN | Channel events arriving from the matrix |
| trigChanOut | output | NUM_CHAN | Inbound channel events passed to the interface |

## Verification
A wrong gate bit appears on the channel outputs in the same cycle that the interface or the matrix drives that channel. It also appears on the read port in any cycle that reads offset 0x140. A write that is lost, or stored despite the lock, shows up from the very next clock edge. The bench keeps its own model of the register and compares every output on every cycle, so such a fault is reported within one cycle of the access that caused it. The bench also runs a second copy with the other direction code. This catches an inbound path that is gated when it should not be, or left open when it should be gated.

// File: rtl/xtrig_gate_pkg.sv
package xtrig_gate_pkg;
  localparam int REG_W = 32;

  typedef struct packed {
    logic wrGate;
    logic rdGate;
  } gateStrobe_t;
endpackage

// File: rtl/xtrig_gate_ctrl.sv
module xtrig_gate_ctrl
  import xtrig_gate_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h140
) (
  input  logic              lockIn,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output gateStrobe_t       strobe
);
  logic hit;

  always_comb begin
    hit = regSel && (regAddr == REG_OFFSET);
    strobe.wrGate = hit && regWr && !lockIn;
    strobe.rdGate = hit && !regWr;
  end
endmodule

// File: rtl/xtrig_gate_dp.sv
module xtrig_gate_dp
  import xtrig_gate_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter logic [1:0] DIR_MODE = 2'b01
) (
  input  logic                clk,
  input  logic                rstN,
  input  gateStrobe_t         strobe,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  input  logic [NUM_CHAN-1:0] trigChanIn,
  output logic [NUM_CHAN-1:0] matrixChanOut,
  input  logic [NUM_CHAN-1:0] matrixChanIn,
  output logic [NUM_CHAN-1:0] trigChanOut,
  output logic [NUM_CHAN-1:0] gateQ
);
  localparam bit GATE_INBOUND = (DIR_MODE == 2'b01);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateQ <= '0;
    else if (strobe.wrGate) gateQ <= regWdata[NUM_CHAN-1:0];
  end

  always_comb begin
    regRdata = '0;
    if (strobe.rdGate) regRdata[NUM_CHAN-1:0] = gateQ;
  end

  assign matrixChanOut = trigChanIn & gateQ;

  generate
    if (GATE_INBOUND) begin : g_inGated
      assign trigChanOut = matrixChanIn & gateQ;
    end else begin : g_inOpen
      assign trigChanOut = matrixChanIn;
    end
  endgenerate
endmodule

// File: rtl/xtrig_gate_top.sv
module xtrig_gate_top
  import xtrig_gate_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter logic [1:0] DIR_MODE = 2'b01,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h140
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lockIn,
  input  logic                regSel,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [NUM_CHAN-1:0] trigChanIn,
  output logic [NUM_CHAN-1:0] matrixChanOut,
  input  logic [NUM_CHAN-1:0] matrixChanIn,
  output logic [NUM_CHAN-1:0] trigChanOut
);
  gateStrobe_t strobe;
  logic [NUM_CHAN-1:0] gateVec;

  xtrig_gate_ctrl #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) ctrl_i (
    .lockIn(lockIn), .regSel(regSel), .regWr(regWr), .regAddr(regAddr),
    .strobe(strobe)
  );

  xtrig_gate_dp #(.NUM_CHAN(NUM_CHAN), .DIR_MODE(DIR_MODE)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata),
    .regRdata(regRdata), .trigChanIn(trigChanIn),
    .matrixChanOut(matrixChanOut), .matrixChanIn(matrixChanIn),
    .trigChanOut(trigChanOut), .gateQ(gateVec)
  );
endmodule

// File: rtl/xtrig_gate_chk.sv
module xtrig_gate_chk #(
  parameter int NUM_CHAN = 4,
  parameter logic [1:0] DIR_MODE = 2'b01,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h140
) (
  input logic                clk,
  input logic                rstN,
  input logic                lockIn,
  input logic                regSel,
  input logic                regWr,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [31:0]         regWdata,
  input logic [31:0]         regRdata,
  input logic [NUM_CHAN-1:0] trigChanIn,
  input logic [NUM_CHAN-1:0] matrixChanOut,
  input logic [NUM_CHAN-1:0] matrixChanIn,
  input logic [NUM_CHAN-1:0] trigChanOut,
  input logic [NUM_CHAN-1:0] gateVec
);
  logic wrHit;
  assign wrHit = regSel && regWr && (regAddr == REG_OFFSET);

  assert_write_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrHit && !lockIn |=> gateVec == $past(regWdata[NUM_CHAN-1:0]));

  generate
    if (NUM_CHAN < 32) begin : g_upper
      assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
        regRdata[31:NUM_CHAN] == '0);
    end
  endgenerate

  assert_out_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    (matrixChanOut & ~gateVec) == '0);

  assert_clear_cuts_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrHit && !lockIn |=> (matrixChanOut & ~$past(regWdata[NUM_CHAN-1:0])) == '0);

  generate
    if (DIR_MODE == 2'b01) begin : g_inChk
      assert_in_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
        (trigChanOut & ~gateVec) == '0);
    end else begin : g_inOpenChk
      assert_in_open_R6: assert property (@(posedge clk) disable iff (!rstN)
        trigChanOut == matrixChanIn);
    end
  endgenerate

  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    lockIn && regSel && regWr |=> $stable(gateVec));

  assert_other_offset_R8: assert property (@(posedge clk) disable iff (!rstN)
    regSel && regWr && (regAddr != REG_OFFSET) |=> $stable(gateVec));
endmodule

bind xtrig_gate_top xtrig_gate_chk #(
  .NUM_CHAN(NUM_CHAN), .DIR_MODE(DIR_MODE), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) chk_i (
  .clk(clk), .rstN(rstN), .lockIn(lockIn), .regSel(regSel), .regWr(regWr),
  .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
  .trigChanIn(trigChanIn), .matrixChanOut(matrixChanOut),
  .matrixChanIn(matrixChanIn), .trigChanOut(trigChanOut), .gateVec(gateVec)
);

// File: tb/xtrig_gate_tb_top.sv
module xtrig_gate_tb_top;
  localparam int N = 4;
  localparam logic [11:0] OFF = 12'h140;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lockIn = 1'b0, regSel = 1'b0, regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [N-1:0] trigChanIn = '0, matrixChanIn = '0;
  logic [31:0] rdA, rdB;
  logic [N-1:0] outA, outB, inA, inB;

  int checks = 0;
  int errors = 0;
  int gateM = 0;

  always #10 clk = ~clk;

  xtrig_gate_top #(.NUM_CHAN(N), .DIR_MODE(2'b01)) dut_i (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdA),
    .trigChanIn(trigChanIn), .matrixChanOut(outA),
    .matrixChanIn(matrixChanIn), .trigChanOut(inA)
  );

  xtrig_gate_top #(.NUM_CHAN(N), .DIR_MODE(2'b00)) dutOpen_i (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdB),
    .trigChanIn(trigChanIn), .matrixChanOut(outB),
    .matrixChanIn(matrixChanIn), .trigChanOut(inB)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural register model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) gateM <= 0;
    else if (regSel && regWr && regAddr == OFF && !lockIn)
      gateM <= int'(regWdata) & ((1 << N) - 1);
  end

  // per-cycle comparison away from the clock edge
  always @(negedge clk) begin
    if (rstN) begin
      int expRd;
      expRd = (regSel && !regWr && regAddr == OFF) ? gateM : 0;
      check("R4 out gated", outA, int'(trigChanIn) & gateM);
      check("R4 out gated open-mode", outB, int'(trigChanIn) & gateM);
      check("R6 inbound gated", inA, int'(matrixChanIn) & gateM);
      check("R6 inbound open", inB, matrixChanIn);
      check("R2 read data", rdA, expRd);
      check("R8 read data open-mode", rdB, expRd);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    regSel = 0; regWr = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    regSel = 1; regWr = 1; regAddr = a; regWdata = d;
    step(); idle();
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    regSel = 1; regWr = 0; regAddr = a;
    @(negedge clk); #1; v = rdA;
    step(); idle();
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    step();
    // R1
    trigChanIn = 4'hF; matrixChanIn = 4'hF;
    rd(OFF, v); check("R1 reset read", v, 0);
    @(negedge clk); #1;
    check("R1 reset out", outA, 0);
    check("R1 reset inbound gated", inA, 0);
    step();
    // R2
    wr(OFF, 32'h5);
    rd(OFF, v); check("R2 readback", v, 32'h5);
    // R3
    wr(OFF, 32'hFFFF_FFFF);
    rd(OFF, v); check("R3 upper bits zero", v, 32'hF);
    wr(OFF, 32'hFFFF_FFF0);
    rd(OFF, v); check("R3 upper writes ignored", v, 32'h0);
    // R4 patterns
    wr(OFF, 32'hA);
    for (int p = 0; p < 16; p++) begin
      trigChanIn = p[N-1:0]; matrixChanIn = ~p[N-1:0];
      @(negedge clk); #1;
      check("R4 pattern", outA, p & 32'hA);
      check("R6 pattern gated", inA, (~p) & 32'hA);
      check("R6 pattern open", inB, (~p) & 32'hF);
      step();
    end
    // R5 held event terminated
    wr(OFF, 32'hF);
    trigChanIn = 4'h4;
    step();
    regSel = 1; regWr = 1; regAddr = OFF; regWdata = 32'hB;
    @(negedge clk); #1;
    check("R5 still high before edge", outA[2], 1);
    @(posedge clk); #1;
    check("R5 cut after edge", outA[2], 0);
    #1 idle();
    step();
    // R7 lock
    lockIn = 1;
    wr(OFF, 32'h0);
    rd(OFF, v); check("R7 locked write ignored", v, 32'hB);
    lockIn = 0;
    // R8 other offset
    wr(12'h144, 32'h0);
    rd(OFF, v); check("R8 other offset no effect", v, 32'hB);
    rd(12'h144, v); check("R8 other offset reads zero", v, 0);
    wr(OFF, 32'h0);
    rd(OFF, v); check("R2 cleared", v, 0);
    repeat (3) step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule